// File: doc/BRIEF.md
# Bundle Commit Tracker

This block follows bundles of operations from in-order dispatch to in-order retirement. Each bundle carries one to five operations, marked by a slot mask. On acceptance the tracker gives the bundle a tag. It keeps one done bit per slot. Execution units later report finished operations by tag and slot index, and those reports arrive in any order. A bundle retires as a whole, and only when it is the oldest bundle held and every slot in its mask has reported.

Bundle state sits in a circular buffer of DEPTH entries, 20 by default, which allows 100 operations in flight. When a speculation turns out wrong, the pipeline names the youngest bundle that must survive. The tracker then drops every younger bundle in a single cycle and leaves older bundles as they were. Freed tags are given out again, starting just after the survivor.

Top module: `bundle_commit_tracker`

## Requirements
- R1: While reset is held and after it is released, `disp_ready` is 1, `commit_valid` is 0 and `disp_tag` is 0.
- R2: An accepted bundle receives the tag shown on `disp_tag` in that cycle. Successive tags count up by one and wrap from DEPTH-1 back to 0.
- R3: When DEPTH bundles are held, `disp_ready` is 0. A dispatch attempted in that state is not accepted and consumes no tag. At most DEPTH bundles are ever held.
- R4: Slots outside a bundle's mask count as finished from dispatch onward. A dispatch with an all-zero mask is ignored and consumes no tag.
- R5: `commit_valid` rises one cycle after the last missing slot of the oldest bundle is reported. In that cycle `commit_tag` and `commit_mask` show that bundle's tag and its dispatched mask, where bit i of the mask is slot i.
- R6: Bundles retire in dispatch order. A finished bundle waits while any older bundle is still unfinished.
- R7: At most one bundle retires per cycle. The bundle shown while `commit_valid` is 1 leaves the buffer at that clock edge.
- R8: A completion report whose tag names no held bundle, or whose slot index is DEPTH-independent but not below SLOTS, changes nothing.
- R9: A flush naming a held tag T drops every bundle younger than T, and the next accepted bundle gets tag T+1 (mod DEPTH). A flush naming a tag that is not held is ignored.
- R10: In any cycle with `flush_valid` high, `disp_ready` is 0 and no bundle is accepted.
- R11: A completion report that arrives in the same cycle as a flush dropping its bundle is lost. A bundle later given the same tag starts with only its unmasked slots finished.
- R12: All NDONE completion ports are applied in the same cycle, including two reports for different bundles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | A bundle is offered for dispatch |
| disp_mask | input | SLOTS | Valid slots of the offered bundle |
| disp_ready | output | 1 | Tracker can accept a bundle this cycle |
| disp_tag | output | TAG_W | Tag the next accepted bundle will get |
| done_valid | input | NDONE | Per-port completion strobe |
| done_tag | input | NDONE*TAG_W | Per-port bundle tag, port p in bits [p*TAG_W +: TAG_W] |
| done_slot | input | NDONE*SLOT_W | Per-port slot index, port p in bits [p*SLOT_W +: SLOT_W] |
| flush_valid | input | 1 | Discard bundles younger than flush_tag |
| flush_tag | input | TAG_W | Youngest bundle that survives the flush |
| commit_valid | output | 1 | Oldest bundle is finished and retires this cycle |
| commit_tag | output | TAG_W | Tag of the retiring bundle |
| commit_mask | output | SLOTS | Dispatched slot mask of the retiring bundle |

## Verification
Two events can hit the same bundle in one cycle: a completion report and a flush that drops that bundle. The bench sends a report for a bundle younger than the flush survivor in the exact cycle the flush is raised. It then dispatches a new bundle that takes the freed tag. The check passes only if the new bundle stays unretired until its own slots are reported, which the reference model predicts cycle by cycle. Random stretches repeat the same mix: flushes, retirements and reports to bundles that are about to be dropped.

// File: rtl/bct_pkg.sv
package bct_pkg;

   typedef enum logic [1:0] {
      RING_HOLD   = 2'b00,
      RING_ALLOC  = 2'b01,
      RING_RETIRE = 2'b10,
      RING_SWAP   = 2'b11
   } ring_op_e;

   // Distance travelled from index 'from' to index 'to' around a ring of 'depth'.
   function automatic int unsigned ring_dist(input int unsigned from,
                                             input int unsigned to,
                                             input int unsigned depth);
      return (to >= from) ? (to - from) : (to + depth - from);
   endfunction

endpackage

// File: rtl/bct_ring_ctrl.sv
module bct_ring_ctrl
   import bct_pkg::*;
#(
   parameter int DEPTH = 20,
   parameter int TAG_W = 5,
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic             flush_valid,
   input  logic [TAG_W-1:0] flush_tag,
   output logic [TAG_W-1:0] head,
   output logic [TAG_W-1:0] tail,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty,
   output logic [DEPTH-1:0] live
);

   logic [TAG_W-1:0] head_q, tail_q, head_d, tail_d;
   logic [CNT_W-1:0] count_q, count_d;
   logic [TAG_W-1:0] head_inc, tail_inc, flush_inc;
   logic [CNT_W-1:0] flush_age;
   logic             flush_hit;
   ring_op_e         op;

   // Pointer increment: free wrap for a power-of-two ring, explicit compare otherwise.
   generate
      if ((1 << TAG_W) == DEPTH) begin : g_pow2
         assign head_inc  = head_q + 1'b1;
         assign tail_inc  = tail_q + 1'b1;
         assign flush_inc = flush_tag + 1'b1;
      end else begin : g_wrap
         assign head_inc  = (head_q    == TAG_W'(DEPTH - 1)) ? '0 : head_q + 1'b1;
         assign tail_inc  = (tail_q    == TAG_W'(DEPTH - 1)) ? '0 : tail_q + 1'b1;
         assign flush_inc = (flush_tag == TAG_W'(DEPTH - 1)) ? '0 : flush_tag + 1'b1;
      end
   endgenerate

   assign flush_age = CNT_W'(ring_dist(int'(head_q), int'(flush_tag), DEPTH));
   assign flush_hit = flush_valid && (int'(flush_tag) < DEPTH) && (flush_age < count_q);

   // Occupancy of every entry follows from its distance to the head.
   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_live
         assign live[e] = CNT_W'(ring_dist(int'(head_q), e, DEPTH)) < count_q;
      end
   endgenerate

   always_comb begin
      op      = ring_op_e'({pop, push});
      head_d  = pop  ? head_inc : head_q;
      tail_d  = push ? tail_inc : tail_q;
      count_d = count_q;
      case (op)
         RING_ALLOC:  count_d = count_q + 1'b1;
         RING_RETIRE: count_d = count_q - 1'b1;
         default:     count_d = count_q;
      endcase
      if (flush_hit) begin
         tail_d  = flush_inc;
         count_d = flush_age + 1'b1 - CNT_W'(pop);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q  <= '0;
         tail_q  <= '0;
         count_q <= '0;
      end else begin
         head_q  <= head_d;
         tail_q  <= tail_d;
         count_q <= count_d;
      end
   end

   assign head  = head_q;
   assign tail  = tail_q;
   assign count = count_q;
   assign full  = (count_q == CNT_W'(DEPTH));
   assign empty = (count_q == '0);

endmodule

// File: rtl/bct_done_decode.sv
module bct_done_decode #(
   parameter int DEPTH  = 20,
   parameter int SLOTS  = 5,
   parameter int NDONE  = 2,
   parameter int TAG_W  = 5,
   parameter int SLOT_W = 3
) (
   input  logic [NDONE-1:0]             done_valid,
   input  logic [NDONE*TAG_W-1:0]       done_tag,
   input  logic [NDONE*SLOT_W-1:0]      done_slot,
   input  logic [DEPTH-1:0]             live,
   output logic [DEPTH-1:0][SLOTS-1:0]  set_bits
);

   logic [NDONE-1:0][DEPTH-1:0][SLOTS-1:0] port_bits;

   // One sparse decode per report port; reports for idle entries fall away here.
   generate
      for (genvar p = 0; p < NDONE; p++) begin : g_port
         logic [TAG_W-1:0]  tag_p;
         logic [SLOT_W-1:0] slot_p;
         assign tag_p  = done_tag[p*TAG_W +: TAG_W];
         assign slot_p = done_slot[p*SLOT_W +: SLOT_W];
         for (genvar e = 0; e < DEPTH; e++) begin : g_ent
            for (genvar s = 0; s < SLOTS; s++) begin : g_slot
               assign port_bits[p][e][s] = done_valid[p] && live[e] &&
                                           (tag_p == TAG_W'(e)) &&
                                           (slot_p == SLOT_W'(s));
            end
         end
      end
   endgenerate

   always_comb begin
      set_bits = '0;
      for (int p = 0; p < NDONE; p++) begin
         set_bits = set_bits | port_bits[p];
      end
   end

endmodule

// File: rtl/bct_group_store.sv
module bct_group_store #(
   parameter int DEPTH = 20,
   parameter int SLOTS = 5,
   parameter int TAG_W = 5
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        alloc,
   input  logic [TAG_W-1:0]            alloc_idx,
   input  logic [SLOTS-1:0]            alloc_mask,
   input  logic [DEPTH-1:0][SLOTS-1:0] set_bits,
   input  logic [TAG_W-1:0]            head,
   output logic [SLOTS-1:0]            head_mask,
   output logic                        head_done
);

   logic [SLOTS-1:0] vmask_all [DEPTH];
   logic [SLOTS-1:0] done_all  [DEPTH];

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_ent
         logic [SLOTS-1:0] vmask_r;
         logic [SLOTS-1:0] done_r;
         logic             hit;

         assign hit = alloc && (alloc_idx == TAG_W'(e));

         // A fresh allocation overrides any report aimed at the same entry.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vmask_r <= '0;
               done_r  <= '1;
            end else if (hit) begin
               vmask_r <= alloc_mask;
               done_r  <= ~alloc_mask;
            end else begin
               done_r  <= done_r | set_bits[e];
            end
         end

         assign vmask_all[e] = vmask_r;
         assign done_all[e]  = done_r;
      end
   endgenerate

   assign head_mask = vmask_all[head];
   assign head_done = &done_all[head];

endmodule

// File: rtl/bundle_commit_tracker.sv
module bundle_commit_tracker #(
   parameter  int SLOTS  = 5,
   parameter  int DEPTH  = 20,
   parameter  int NDONE  = 2,
   localparam int TAG_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    disp_valid,
   input  logic [SLOTS-1:0]        disp_mask,
   output logic                    disp_ready,
   output logic [TAG_W-1:0]        disp_tag,
   input  logic [NDONE-1:0]        done_valid,
   input  logic [NDONE*TAG_W-1:0]  done_tag,
   input  logic [NDONE*SLOT_W-1:0] done_slot,
   input  logic                    flush_valid,
   input  logic [TAG_W-1:0]        flush_tag,
   output logic                    commit_valid,
   output logic [TAG_W-1:0]        commit_tag,
   output logic [SLOTS-1:0]        commit_mask
);

   localparam int CNT_W = $clog2(DEPTH + 1);

   generate
      if (SLOTS < 1 || SLOTS > 16) begin : g_bad_slots
         $error("bundle_commit_tracker: SLOTS out of range");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("bundle_commit_tracker: DEPTH must be at least 2");
      end
      if (NDONE < 1) begin : g_bad_ports
         $error("bundle_commit_tracker: NDONE must be at least 1");
      end
   endgenerate

   logic [TAG_W-1:0]            ring_head, ring_tail;
   logic [CNT_W-1:0]            ring_count;
   logic                        ring_full, ring_empty;
   logic [DEPTH-1:0]            ring_live;
   logic [DEPTH-1:0][SLOTS-1:0] slot_set;
   logic [SLOTS-1:0]            head_mask;
   logic                        head_done;
   logic                        accept, retire;

   assign disp_ready = !ring_full && !flush_valid;
   assign accept     = disp_valid && disp_ready && (|disp_mask);
   assign retire     = !ring_empty && head_done;

   bct_ring_ctrl #(
      .DEPTH (DEPTH),
      .TAG_W (TAG_W),
      .CNT_W (CNT_W)
   ) u_ring (
      .clk         (clk),
      .rst_n       (rst_n),
      .push        (accept),
      .pop         (retire),
      .flush_valid (flush_valid),
      .flush_tag   (flush_tag),
      .head        (ring_head),
      .tail        (ring_tail),
      .count       (ring_count),
      .full        (ring_full),
      .empty       (ring_empty),
      .live        (ring_live)
   );

   bct_done_decode #(
      .DEPTH  (DEPTH),
      .SLOTS  (SLOTS),
      .NDONE  (NDONE),
      .TAG_W  (TAG_W),
      .SLOT_W (SLOT_W)
   ) u_decode (
      .done_valid (done_valid),
      .done_tag   (done_tag),
      .done_slot  (done_slot),
      .live       (ring_live),
      .set_bits   (slot_set)
   );

   bct_group_store #(
      .DEPTH (DEPTH),
      .SLOTS (SLOTS),
      .TAG_W (TAG_W)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc      (accept),
      .alloc_idx  (ring_tail),
      .alloc_mask (disp_mask),
      .set_bits   (slot_set),
      .head       (ring_head),
      .head_mask  (head_mask),
      .head_done  (head_done)
   );

   assign disp_tag     = ring_tail;
   assign commit_valid = retire;
   assign commit_tag   = ring_head;
   assign commit_mask  = head_mask;

endmodule

// File: rtl/bct_checker.sv
module bct_checker
   import bct_pkg::*;
#(
   parameter int SLOTS = 5,
   parameter int DEPTH = 20,
   parameter int TAG_W = 5,
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             disp_valid,
   input logic [SLOTS-1:0] disp_mask,
   input logic             disp_ready,
   input logic [TAG_W-1:0] disp_tag,
   input logic             flush_valid,
   input logic [TAG_W-1:0] flush_tag,
   input logic             commit_valid,
   input logic [TAG_W-1:0] commit_tag,
   input logic [SLOTS-1:0] commit_mask,
   input logic [CNT_W-1:0] count
);

   logic [TAG_W-1:0] disp_next, commit_next, flush_next;
   logic             took, flush_hit;

   assign disp_next   = (disp_tag   == TAG_W'(DEPTH - 1)) ? '0 : disp_tag + 1'b1;
   assign commit_next = (commit_tag == TAG_W'(DEPTH - 1)) ? '0 : commit_tag + 1'b1;
   assign flush_next  = (flush_tag  == TAG_W'(DEPTH - 1)) ? '0 : flush_tag + 1'b1;
   assign took        = disp_valid && disp_ready && (|disp_mask);
   assign flush_hit   = flush_valid && (int'(flush_tag) < DEPTH) &&
                        (CNT_W'(ring_dist(int'(commit_tag), int'(flush_tag), DEPTH)) < count);

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   p_full_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CNT_W'(DEPTH)) |-> !disp_ready);

   p_tag_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      took |=> (disp_tag == $past(disp_next)));

   p_commit_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
      commit_valid |-> ((count != '0) && (commit_mask != '0)));

   p_retire_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
      commit_valid |=> (commit_tag == $past(commit_next)));

   p_head_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_valid |=> $stable(commit_tag));

   p_flush_tail_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush_hit |=> (disp_tag == $past(flush_next)));

   p_flush_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush_valid |-> !disp_ready);

endmodule

bind bundle_commit_tracker bct_checker #(
   .SLOTS (SLOTS),
   .DEPTH (DEPTH),
   .TAG_W (TAG_W),
   .CNT_W (CNT_W)
) u_bct_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .disp_valid   (disp_valid),
   .disp_mask    (disp_mask),
   .disp_ready   (disp_ready),
   .disp_tag     (disp_tag),
   .flush_valid  (flush_valid),
   .flush_tag    (flush_tag),
   .commit_valid (commit_valid),
   .commit_tag   (commit_tag),
   .commit_mask  (commit_mask),
   .count        (ring_count)
);

// File: tb/bundle_commit_tracker_tb_top.sv
`timescale 1ns/1ps
module bundle_commit_tracker_tb_top;

   localparam int SLOTS  = 5;
   localparam int DEPTH  = 20;
   localparam int NDONE  = 2;
   localparam int TAG_W  = 5;
   localparam int SLOT_W = 3;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    dv = 1'b0;
   logic [SLOTS-1:0]        dmask = '0;
   logic                    disp_ready;
   logic [TAG_W-1:0]        disp_tag;
   logic [NDONE-1:0]        cv = '0;
   logic [NDONE*TAG_W-1:0]  ctag = '0;
   logic [NDONE*SLOT_W-1:0] cslot = '0;
   logic                    fv = 1'b0;
   logic [TAG_W-1:0]        ftag = '0;
   logic                    commit_valid;
   logic [TAG_W-1:0]        commit_tag;
   logic [SLOTS-1:0]        commit_mask;

   int    n_chk = 0;
   int    n_fail = 0;
   bit    finished = 0;
   string cur_req = "R1";

   // Reference model: oldest bundle at index 0.
   int               q_tag[$];
   logic [SLOTS-1:0] q_mask[$];
   logic [SLOTS-1:0] q_done[$];
   int               next_tag = 0;

   always #10 clk = ~clk;

   bundle_commit_tracker #(.SLOTS(SLOTS), .DEPTH(DEPTH), .NDONE(NDONE)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .disp_valid   (dv),
      .disp_mask    (dmask),
      .disp_ready   (disp_ready),
      .disp_tag     (disp_tag),
      .done_valid   (cv),
      .done_tag     (ctag),
      .done_slot    (cslot),
      .flush_valid  (fv),
      .flush_tag    (ftag),
      .commit_valid (commit_valid),
      .commit_tag   (commit_tag),
      .commit_mask  (commit_mask)
   );

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
      end
   endtask

   function automatic int find_tag(input int t);
      for (int i = 0; i < q_tag.size(); i++) if (q_tag[i] == t) return i;
      return -1;
   endfunction

   task automatic report(input int p, input int t, input int s);
      cv[p] = 1'b1;
      ctag[p*TAG_W +: TAG_W]    = TAG_W'(t);
      cslot[p*SLOT_W +: SLOT_W] = SLOT_W'(s);
   endtask

   // Compare outputs, advance model, cross one clock edge, clear inputs.
   task automatic tick();
      bit exp_ready, exp_cv;
      int k;
      logic [SLOTS-1:0] tmp;
      #1;
      exp_ready = (q_tag.size() < DEPTH) && !fv;
      exp_cv    = (q_tag.size() > 0) && (&q_done[0]);
      chk(disp_ready == exp_ready, "disp_ready", int'(disp_ready), int'(exp_ready));
      chk(int'(disp_tag) == next_tag, "disp_tag", int'(disp_tag), next_tag);
      chk(commit_valid == exp_cv, "commit_valid", int'(commit_valid), int'(exp_cv));
      if (exp_cv && commit_valid) begin
         chk(int'(commit_tag) == q_tag[0], "commit_tag", int'(commit_tag), q_tag[0]);
         chk(commit_mask == q_mask[0], "commit_mask", int'(commit_mask), int'(q_mask[0]));
      end
      for (int p = 0; p < NDONE; p++) begin
         if (cv[p]) begin
            k = find_tag(int'(ctag[p*TAG_W +: TAG_W]));
            if (k >= 0 && int'(cslot[p*SLOT_W +: SLOT_W]) < SLOTS) begin
               tmp = q_done[k];
               tmp[cslot[p*SLOT_W +: SLOT_W]] = 1'b1;
               q_done[k] = tmp;
            end
         end
      end
      k = fv ? find_tag(int'(ftag)) : -1;
      if (k >= 0) begin
         while (q_tag.size() > k + 1) begin
            void'(q_tag.pop_back());
            void'(q_mask.pop_back());
            void'(q_done.pop_back());
         end
         next_tag = (int'(ftag) + 1) % DEPTH;
      end
      if (exp_cv) begin
         void'(q_tag.pop_front());
         void'(q_mask.pop_front());
         void'(q_done.pop_front());
      end
      if (dv && exp_ready && dmask != '0) begin
         q_tag.push_back(next_tag);
         q_mask.push_back(dmask);
         q_done.push_back(~dmask);
         next_tag = (next_tag + 1) % DEPTH;
      end
      @(posedge clk);
      @(negedge clk);
      dv = 1'b0; dmask = '0; cv = '0; fv = 1'b0;
   endtask

   task automatic disp(input logic [SLOTS-1:0] m);
      dv = 1'b1; dmask = m; tick();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic finish_group(input int t);
      for (int s = 0; s < SLOTS; s += 2) begin
         report(0, t, s);
         if (s + 1 < SLOTS) report(1, t, s + 1);
         tick();
      end
   endtask

   task automatic drain();
      while (q_tag.size() > 0) begin
         finish_group(q_tag[q_tag.size()-1]);
         for (int i = 0; i < q_tag.size(); i++) finish_group(q_tag[i]);
         idle(DEPTH + 2);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : stim
      int t0, t1, t2;
      // R1: reset values, during and after reset
      repeat (3) @(negedge clk);
      chk(disp_ready == 1'b1, "reset disp_ready", int'(disp_ready), 1);
      chk(commit_valid == 1'b0, "reset commit_valid", int'(commit_valid), 0);
      chk(disp_tag == '0, "reset disp_tag", int'(disp_tag), 0);
      rst_n = 1'b1;
      idle(2);

      // R2 / R5: dispatch varied masks, finish the oldest
      cur_req = "R2";
      disp(5'b11111); disp(5'b00011); disp(5'b10000);
      cur_req = "R5";
      finish_group(0);
      idle(2);

      // R6: younger bundle finished first must wait for the older one
      cur_req = "R6";
      report(0, 2, 4); tick();
      idle(3);
      report(0, 1, 0); report(1, 1, 1); tick();
      idle(3);

      // R7: several finished bundles leave one per cycle
      cur_req = "R7";
      t0 = next_tag;
      disp(5'b00001); disp(5'b00001); disp(5'b00001);
      report(0, t0, 0); report(1, (t0+1)%DEPTH, 0); tick();
      report(0, (t0+2)%DEPTH, 0); tick();
      idle(4);

      // R4: empty mask ignored; partial mask needs only its own slots
      cur_req = "R4";
      disp(5'b00000);
      idle(1);
      t0 = next_tag;
      disp(5'b01001);
      report(0, t0, 0); tick();
      idle(2);
      report(0, t0, 3); tick();
      idle(2);

      // R8: reports to idle tags and out-of-range slots change nothing
      cur_req = "R8";
      t0 = next_tag;
      disp(5'b00001);
      report(0, (t0+5)%DEPTH, 0); report(1, t0, 6); tick();
      idle(3);
      report(0, t0, 0); tick();
      idle(2);

      // R3: fill the ring, then press on while full (also wraps tags, R2)
      cur_req = "R3";
      for (int i = 0; i < DEPTH; i++) disp(5'b00001);
      chk(disp_ready == 1'b0, "full disp_ready", int'(disp_ready), 0);
      disp(5'b00001); disp(5'b11111);
      report(0, q_tag[0], 0); tick();
      idle(2);
      cur_req = "R2";
      disp(5'b00011);
      drain();

      // R9 / R10: selective flush keeps the older bundles
      cur_req = "R9";
      for (int i = 0; i < 5; i++) disp(5'b00011);
      t1 = q_tag[1];
      cur_req = "R10";
      dv = 1'b1; dmask = 5'b00001; fv = 1'b1; ftag = TAG_W'(t1); tick();
      cur_req = "R9";
      disp(5'b00001);
      fv = 1'b1; ftag = TAG_W'((t1 + 7) % DEPTH); tick();
      idle(2);
      drain();

      // R11: report collides with a flush that drops its bundle
      cur_req = "R11";
      t0 = next_tag;
      disp(5'b00001); disp(5'b00001); disp(5'b00001);
      fv = 1'b1; ftag = TAG_W'(t0);
      report(0, (t0+1)%DEPTH, 0); report(1, (t0+2)%DEPTH, 0); tick();
      disp(5'b00001);
      report(0, t0, 0); tick();
      idle(4);
      drain();

      // R12: both ports, different bundles, same cycle
      cur_req = "R12";
      t0 = next_tag;
      disp(5'b00001); disp(5'b00010);
      report(0, t0, 0); report(1, (t0+1)%DEPTH, 1); tick();
      idle(3);

      // Mixed random traffic against the model (R6 ordering under load)
      cur_req = "R6";
      for (int c = 0; c < 3000; c++) begin
         if ($urandom_range(0, 2) != 0) begin dv = 1'b1; dmask = SLOTS'($urandom_range(0, 31)); end
         for (int p = 0; p < NDONE; p++) begin
            if (q_tag.size() > 0 && $urandom_range(0, 3) != 0) begin
               t2 = $urandom_range(0, q_tag.size() - 1);
               report(p, q_tag[t2], $urandom_range(0, SLOTS));
            end
         end
         if ($urandom_range(0, 15) == 0) begin
            fv = 1'b1;
            if (q_tag.size() > 0 && $urandom_range(0, 3) != 0)
               ftag = TAG_W'(q_tag[$urandom_range(0, q_tag.size() - 1)]);
            else
               ftag = TAG_W'($urandom_range(0, 31));
         end
         tick();
      end
      drain();

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule